// File: doc/BRIEF.md
# Crossbar Master-Port Access Classifier

This block sits at the master side of one crossbar master port. Every cycle in which the port accepts an address phase, it looks at the master's select, transfer type, address and control, and decides what happens to that transfer. There are five outcomes. An unselected cycle is dropped. A selected IDLE transfer is answered at once and goes nowhere. A transfer to a slave port that already belongs to this master goes straight onto the slave bus. A transfer to a slave port held elsewhere is queued. An address outside the map draws an error.

A queued transfer differs from a plain wait state. The master sees its address phase accepted. The block copies the address and control into a holding register and raises a request to the target slave port's arbiter. It then keeps master ready low. When the grant arrives, the held transfer is replayed onto the slave bus in the next cycle. Master ready returns only when that replayed data phase completes. The address map is a small parameter table of base and mask pairs, one pair per slave port. When entries overlap, the lowest index wins.

Top module: `xbar_mport_classifier`

## Requirements
- R1: A cycle accepted with select low forwards nothing: no slave select, no request, and master ready stays high with an okay response in the next cycle.
- R2: A selected transfer of type IDLE (encoding 00) forwards nothing and gets an okay response with no wait: in the next cycle master ready is high and the error response is low.
- R3: A selected non-IDLE transfer whose target port is marked as serving or parked on this master drives, in the same cycle, the one-hot slave select of that port together with the master's address, transfer type, write flag and size.
- R4: During the data phase of a passed-through transfer, master ready follows slave ready.
- R5: A selected non-IDLE transfer whose target port is not marked for this master forwards nothing in that cycle. From the next cycle the block drives master ready low and raises a one-hot request to that port.
- R6: The request stays raised and master ready stays low for as long as the grant for the requested port is absent. This holds even if the master's inputs change.
- R7: In the cycle after the grant, the slave bus carries the held address and control with the target's slave select, even if the master's inputs have changed. It stays there until slave ready is seen high.
- R8: After the replayed address is taken, master ready follows slave ready for that data phase.
- R9: A selected non-IDLE transfer whose address matches no map entry is never forwarded. It produces a two-cycle error response: first ready low with the error high, then ready high with the error high.
- R10: Transfer types are encoded as 00 IDLE, 01 BUSY, 10 NONSEQ and 11 SEQ. BUSY counts as non-IDLE. Port i is hit when the address ANDed with mask i equals base i.
- R11: After reset, master ready is high, the error response is low, and no slave select or request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_sel | input | 1 | Master select |
| m_trans | input | 2 | Master transfer type |
| m_addr | input | AW | Master address |
| m_write | input | 1 | Master write flag |
| m_size | input | 3 | Master transfer size |
| m_ready | output | 1 | Ready returned to the master |
| m_resp | output | 1 | Error response to the master |
| sp_mine | input | NS | Per slave port: serving or parked on this master |
| sp_grant | input | NS | Per slave port: arbitration grant to this master |
| sp_req | output | NS | Per slave port: arbitration request |
| s_ready | input | 1 | Ready from the slave side |
| s_sel | output | NS | One-hot slave port select |
| s_trans | output | 2 | Transfer type on the slave bus |
| s_addr | output | AW | Address on the slave bus |
| s_write | output | 1 | Write flag on the slave bus |
| s_size | output | 3 | Size on the slave bus |

## Verification
The bench builds the block with its defaults: four slave ports, 32-bit addresses, ports 0 to 2 on 256 MB regions at 0x0, 0x1000_0000 and 0x2000_0000, and port 3 on the wider 1 GB region from 0x4000_0000. This reaches all five outcomes on more than one port. It also reaches the gaps at 0x3000_0000 and 0x8000_0000 for unmapped errors, and the edge of port 3's wider mask at 0x7FFF_FFF0. Because there are several ports, the bench can check that requests and slave selects land on the right one-hot bit. The directed tests also change the master inputs while a stall is pending, which shows that the replay comes from held state.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_t;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_WAIT,
        ST_REPLAY,
        ST_DATA,
        ST_ERR1,
        ST_ERR2
    } state_t;

    typedef enum logic [2:0] {
        V_IGNORE,
        V_TERM,
        V_PASS,
        V_STALL,
        V_MISS
    } verdict_t;

    typedef struct packed {
        logic       write;
        logic [2:0] size;
        trans_t     trans;
    } ctl_t;

    function automatic verdict_t classify(input logic sel, input logic [1:0] trans,
                                          input logic hit, input logic mine);
        verdict_t v;
        if (!sel)                          v = V_IGNORE;
        else if (trans == 2'(TR_IDLE))     v = V_TERM;
        else if (!hit)                     v = V_MISS;
        else if (mine)                     v = V_PASS;
        else                               v = V_STALL;
        return v;
    endfunction

endpackage

// File: rtl/mpc_decode.sv
module mpc_decode #(
    parameter int NS = 4,
    parameter int AW = 32,
    parameter int PW = (NS > 1) ? $clog2(NS) : 1,
    parameter logic [NS-1:0][AW-1:0] MAP_BASE = '0,
    parameter logic [NS-1:0][AW-1:0] MAP_MASK = '0
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [PW-1:0] port
);
    logic [NS-1:0] match;

    for (genvar i = 0; i < NS; i++) begin : g_cmp
        assign match[i] = ((addr & MAP_MASK[i]) == MAP_BASE[i]);
    end

    always_comb begin
        hit  = 1'b0;
        port = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                port = PW'(i);
            end
        end
    end
endmodule

// File: rtl/mpc_hold.sv
module mpc_hold
    import mpc_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  ctl_t          ctl_in,
    input  logic [PW-1:0] port_in,
    output logic [AW-1:0] addr_q,
    output ctl_t          ctl_q,
    output logic [PW-1:0] port_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ctl_q  <= '0;
            port_q <= '0;
        end else if (load) begin
            addr_q <= addr_in;
            ctl_q  <= ctl_in;
            port_q <= port_in;
        end
    end
endmodule

// File: rtl/mpc_ctrl.sv
module mpc_ctrl
    import mpc_pkg::*;
#(
    parameter int NS = 4,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  verdict_t      verdict,
    input  logic [PW-1:0] held_port,
    input  logic [NS-1:0] sp_grant,
    input  logic          s_ready,
    output logic          m_ready,
    output logic          m_resp,
    output logic          accept,
    output logic          load,
    output logic          replay,
    output logic [NS-1:0] sp_req
);
    state_t state, state_nx;
    logic   dpass, dpass_nx;

    always_comb begin
        case (state)
            ST_RUN:    m_ready = dpass ? s_ready : 1'b1;
            ST_DATA:   m_ready = s_ready;
            ST_ERR2:   m_ready = 1'b1;
            default:   m_ready = 1'b0;
        endcase
        m_resp = (state == ST_ERR1) || (state == ST_ERR2);
        accept = m_ready;
        replay = (state == ST_REPLAY);
        sp_req = (state == ST_WAIT) ? (NS'(1) << held_port) : '0;
    end

    always_comb begin
        state_nx = state;
        dpass_nx = dpass;
        load     = 1'b0;
        if (accept) begin
            dpass_nx = 1'b0;
            case (verdict)
                V_PASS:  begin state_nx = ST_RUN;  dpass_nx = 1'b1; end
                V_STALL: begin state_nx = ST_WAIT; load = 1'b1;     end
                V_MISS:  state_nx = ST_ERR1;
                default: state_nx = ST_RUN;
            endcase
        end else begin
            case (state)
                ST_WAIT:   if (sp_grant[held_port]) state_nx = ST_REPLAY;
                ST_REPLAY: if (s_ready) state_nx = ST_DATA;
                ST_ERR1:   state_nx = ST_ERR2;
                default:   state_nx = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            dpass <= 1'b0;
        end else begin
            state <= state_nx;
            dpass <= dpass_nx;
        end
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sp_req)); // R5
    AST_WAIT_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (sp_req != '0) |-> !m_ready); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((sp_req != '0) && ((sp_req & sp_grant) == '0)) |=> (sp_req == $past(sp_req))); // R6
    AST_ERR_SEQ: assert property (@(posedge clk) disable iff (rst)
        (m_resp && !m_ready) |=> (m_resp && m_ready)); // R9
endmodule

// File: rtl/xbar_mport_classifier.sv
module xbar_mport_classifier
    import mpc_pkg::*;
#(
    parameter int NS = 4,
    parameter int AW = 32,
    parameter logic [NS-1:0][AW-1:0] MAP_BASE =
        {32'h4000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
    parameter logic [NS-1:0][AW-1:0] MAP_MASK =
        {32'hC000_0000, 32'hF000_0000, 32'hF000_0000, 32'hF000_0000}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          m_sel,
    input  logic [1:0]    m_trans,
    input  logic [AW-1:0] m_addr,
    input  logic          m_write,
    input  logic [2:0]    m_size,
    output logic          m_ready,
    output logic          m_resp,
    input  logic [NS-1:0] sp_mine,
    input  logic [NS-1:0] sp_grant,
    output logic [NS-1:0] sp_req,
    input  logic          s_ready,
    output logic [NS-1:0] s_sel,
    output logic [1:0]    s_trans,
    output logic [AW-1:0] s_addr,
    output logic          s_write,
    output logic [2:0]    s_size
);
    localparam int PW = (NS > 1) ? $clog2(NS) : 1;

    logic          hit;
    logic [PW-1:0] tgt_port;
    logic [PW-1:0] held_port;
    logic [AW-1:0] held_addr;
    ctl_t          held_ctl;
    ctl_t          m_ctl;
    verdict_t      verdict;
    logic          accept, load, replay;

    assign m_ctl   = '{write: m_write, size: m_size, trans: trans_t'(m_trans)};
    assign verdict = classify(m_sel, m_trans, hit, sp_mine[tgt_port]);

    mpc_decode #(.NS(NS), .AW(AW), .PW(PW), .MAP_BASE(MAP_BASE), .MAP_MASK(MAP_MASK))
    u_decode (
        .addr (m_addr),
        .hit  (hit),
        .port (tgt_port)
    );

    mpc_hold #(.AW(AW), .PW(PW)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .addr_in (m_addr),
        .ctl_in  (m_ctl),
        .port_in (tgt_port),
        .addr_q  (held_addr),
        .ctl_q   (held_ctl),
        .port_q  (held_port)
    );

    mpc_ctrl #(.NS(NS), .PW(PW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .verdict   (verdict),
        .held_port (held_port),
        .sp_grant  (sp_grant),
        .s_ready   (s_ready),
        .m_ready   (m_ready),
        .m_resp    (m_resp),
        .accept    (accept),
        .load      (load),
        .replay    (replay),
        .sp_req    (sp_req)
    );

    always_comb begin
        s_sel   = '0;
        s_trans = 2'(TR_IDLE);
        s_addr  = '0;
        s_write = 1'b0;
        s_size  = '0;
        if (replay) begin
            s_sel   = NS'(1) << held_port;
            s_trans = held_ctl.trans;
            s_addr  = held_addr;
            s_write = held_ctl.write;
            s_size  = held_ctl.size;
        end else if (accept && (verdict == V_PASS)) begin
            s_sel   = NS'(1) << tgt_port;
            s_trans = m_trans;
            s_addr  = m_addr;
            s_write = m_write;
            s_size  = m_size;
        end
    end

    AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (accept && !m_sel) |-> (s_sel == '0)); // R1
    AST_SSEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_sel)); // R3
    AST_ERR_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        m_resp |-> (s_sel == '0)); // R9
    AST_REPLAY_TARGET: assert property (@(posedge clk) disable iff (rst)
        ($past(sp_req & sp_grant) != '0) |-> (s_sel == $past(sp_req))); // R7
endmodule

// File: tb/xbar_mport_classifier_bench.sv
module xbar_mport_classifier_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        m_sel;
    logic [1:0]  m_trans;
    logic [31:0] m_addr;
    logic        m_write;
    logic [2:0]  m_size;
    logic        m_ready, m_resp;
    logic [3:0]  sp_mine, sp_grant, sp_req, s_sel;
    logic        s_ready;
    logic [1:0]  s_trans;
    logic [31:0] s_addr;
    logic        s_write;
    logic [2:0]  s_size;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    xbar_mport_classifier u_xbar_mport_classifier (
        .clk(clk), .rst(rst), .m_sel(m_sel), .m_trans(m_trans), .m_addr(m_addr),
        .m_write(m_write), .m_size(m_size), .m_ready(m_ready), .m_resp(m_resp),
        .sp_mine(sp_mine), .sp_grant(sp_grant), .sp_req(sp_req), .s_ready(s_ready),
        .s_sel(s_sel), .s_trans(s_trans), .s_addr(s_addr), .s_write(s_write),
        .s_size(s_size)
    );

    typedef struct packed {
        logic        sel;
        logic [1:0]  tr;
        logic [31:0] addr;
        logic [3:0]  mine;
        logic [3:0]  essel;
        logic        erdy;
        logic        eresp;
        logic [3:0]  ereq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'b10, 32'h1000_0000, 4'b0101, 4'b0000, 1'b1, 1'b0, 4'b0000}, // R1
        '{1'b1, 2'b00, 32'h0000_0000, 4'b0101, 4'b0000, 1'b1, 1'b0, 4'b0000}, // R2
        '{1'b1, 2'b10, 32'h0000_0010, 4'b0101, 4'b0001, 1'b1, 1'b0, 4'b0000}, // R3
        '{1'b1, 2'b11, 32'h2000_0004, 4'b0101, 4'b0100, 1'b1, 1'b0, 4'b0000}, // R3
        '{1'b1, 2'b10, 32'h1000_0000, 4'b0101, 4'b0000, 1'b0, 1'b0, 4'b0010}, // R5
        '{1'b1, 2'b01, 32'h4000_0000, 4'b0101, 4'b0000, 1'b0, 1'b0, 4'b1000}, // R10
        '{1'b1, 2'b10, 32'h7FFF_FFF0, 4'b0101, 4'b0000, 1'b0, 1'b0, 4'b1000}, // R10
        '{1'b1, 2'b10, 32'h8000_0000, 4'b0101, 4'b0000, 1'b0, 1'b1, 4'b0000}, // R9
        '{1'b1, 2'b00, 32'h8000_0000, 4'b0101, 4'b0000, 1'b1, 1'b0, 4'b0000}, // R2
        '{1'b1, 2'b11, 32'h3000_0000, 4'b1111, 4'b0000, 1'b0, 1'b1, 4'b0000}  // R9
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_master();
        m_sel   = 1'b0;
        m_trans = 2'b00;
        m_addr  = 32'h0;
        m_write = 1'b0;
        m_size  = 3'd0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1;
        idle_master();
        sp_mine  = 4'b0101;
        sp_grant = 4'b0000;
        s_ready  = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();

        check("R11 ready", 32'(m_ready), 32'd1);
        check("R11 resp", 32'(m_resp), 32'd0);
        check("R11 ssel", 32'(s_sel), 32'd0);
        check("R11 req", 32'(sp_req), 32'd0);

        for (int i = 0; i < NV; i++) begin
            m_sel   = VEC[i].sel;
            m_trans = VEC[i].tr;
            m_addr  = VEC[i].addr;
            sp_mine = VEC[i].mine;
            #1;
            check($sformatf("R3/R5 vec%0d ssel", i), 32'(s_sel), 32'(VEC[i].essel));
            tick();
            idle_master();
            #1;
            check($sformatf("R1/R2/R5/R9 vec%0d ready", i), 32'(m_ready), 32'(VEC[i].erdy));
            check($sformatf("R2/R9 vec%0d resp", i), 32'(m_resp), 32'(VEC[i].eresp));
            check($sformatf("R5/R10 vec%0d req", i), 32'(sp_req), 32'(VEC[i].ereq));
            sp_grant = 4'b1111;
            for (int k = 0; k < 4; k++) tick();
            sp_grant = 4'b0000;
            sp_mine  = 4'b0101;
        end

        // Full stall sequence with master inputs changed while pending
        m_sel = 1'b1; m_trans = 2'b10; m_addr = 32'h1000_0040; m_write = 1'b1; m_size = 3'd2;
        #1;
        check("R5 stall no fwd", 32'(s_sel), 32'd0);
        tick();
        m_sel = 1'b0; m_addr = 32'h0000_0000; m_write = 1'b0; m_size = 3'd0; m_trans = 2'b00;
        #1;
        check("R5 req raised", 32'(sp_req), 32'b0010);
        check("R5 ready low", 32'(m_ready), 32'd0);
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R6 req held", 32'(sp_req), 32'b0010);
            check("R6 ready low", 32'(m_ready), 32'd0);
        end
        sp_grant = 4'b0010;
        s_ready  = 1'b0;
        tick();
        sp_grant = 4'b0000;
        #1;
        check("R7 replay ssel", 32'(s_sel), 32'b0010);
        check("R7 replay addr", s_addr, 32'h1000_0040);
        check("R7 replay write", 32'(s_write), 32'd1);
        check("R7 replay size", 32'(s_size), 32'd2);
        check("R7 replay trans", 32'(s_trans), 32'd2);
        check("R7 replay ready", 32'(m_ready), 32'd0);
        check("R7 req dropped", 32'(sp_req), 32'd0);
        tick();
        check("R7 replay kept", 32'(s_sel), 32'b0010);
        s_ready = 1'b1;
        tick();
        s_ready = 1'b0;
        #1;
        check("R8 data wait", 32'(m_ready), 32'd0);
        check("R8 no fwd", 32'(s_sel), 32'd0);
        s_ready = 1'b1;
        #1;
        check("R8 data done", 32'(m_ready), 32'd1);
        tick();

        // Passed-through data phase
        m_sel = 1'b1; m_trans = 2'b10; m_addr = 32'h2000_0008; m_write = 1'b0; m_size = 3'd1;
        #1;
        check("R3 pass addr", s_addr, 32'h2000_0008);
        check("R3 pass size", 32'(s_size), 32'd1);
        check("R3 pass trans", 32'(s_trans), 32'd2);
        check("R3 pass write", 32'(s_write), 32'd0);
        tick();
        idle_master();
        s_ready = 1'b0;
        #1;
        check("R4 follow low", 32'(m_ready), 32'd0);
        s_ready = 1'b1;
        #1;
        check("R4 follow high", 32'(m_ready), 32'd1);
        tick();

        // Two-cycle error response
        m_sel = 1'b1; m_trans = 2'b10; m_addr = 32'hC000_0000;
        tick();
        idle_master();
        #1;
        check("R9 err c1 ready", 32'(m_ready), 32'd0);
        check("R9 err c1 resp", 32'(m_resp), 32'd1);
        tick();
        check("R9 err c2 ready", 32'(m_ready), 32'd1);
        check("R9 err c2 resp", 32'(m_resp), 32'd1);
        check("R9 err no fwd", 32'(s_sel), 32'd0);
        tick();
        check("R9 err over", 32'(m_resp), 32'd0);
        check("R1 idle ready", 32'(m_ready), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule